// File: doc/BRIEF.md
# Accuracy-Configurable Timing-Error Masking Unit

This unit sits beside a single-precision floating-point pipeline. Error-detection sensors on the 32-bit result word report one timing-error flag per bit. For each result that leaves the pipeline, the unit decides whether a flagged error forces the operation to be replayed by the correction unit, or whether the error can be let through. The correction unit replays at the same clock frequency. The result word has three fields: bit 31 is the sign, bits 30..23 are the exponent and bits 22..0 are the fraction.

Every operation is issued as either accurate or approximate. A software-writable register holds a count N of low fraction bits. In approximate mode, errors on fraction bits 0..N-1 are ignored. Errors on the sign and exponent bits always cause a replay. The mode and N are captured when an operation is issued and travel with it through a tag pipeline that matches the datapath depth. Accurate and approximate operations can therefore be interleaved back to back, and rewriting N affects only operations issued after the write. A second output reports every error a sensor flags, whatever the mask says, so that monitoring logic can count errors.

Issue and result flow follow the pipeline advance strobe `pipe_adv`, which acts as the ready signal of the issue interface. An operation is accepted only in a cycle where both `op_valid` and `pipe_adv` are high. While `pipe_adv` is low, upstream must hold the operation and the tag pipeline holds its contents. The outputs are single-cycle pulses with no back-pressure: the correction unit and the monitor must accept them in the cycle they appear.

Top module: `fp_err_mask_unit`

## Requirements
- R1: After reset, `replay_req` and `err_seen` are 0 and N is 0. With N = 0, an approximate operation masks no bit.
- R2: For an accurate operation, a flag on any of bits 31..0 raises `replay_req`.
- R3: For an approximate operation whose only flags lie on fraction bits below N, `replay_req` stays 0 and `err_seen` is 1.
- R4: For an approximate operation, a flag on a fraction bit at position N or higher (up to bit 22) raises `replay_req`.
- R5: A flag on the sign bit (31) or on any exponent bit (30..23) raises `replay_req` in either mode and for any N.
- R6: A write of a value above 23 to `cfg_nbits` stores 23. A flag on bit 22 is then masked, and a flag on bit 23 still replays.
- R7: Mode and N are captured at issue. A write to N in the same cycle as the issue, or while the operation is in flight, does not change how that operation is masked.
- R8: `err_seen` is 1 exactly when a valid operation leaves the pipeline with any flag set, in either mode. Both outputs are 0 when no valid operation leaves.
- R9: The flags for an operation are sampled at the DEPTH-th advance after its issue, and the outputs pulse in the following cycle. While `pipe_adv` is low, nothing leaves and both outputs are 0.
- R10: Accurate and approximate operations issued in consecutive cycles are each masked by their own mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Write strobe for the masked-bit count register |
| cfg_nbits | input | 5 | New value of N. Values above 23 are clamped to 23 |
| op_valid | input | 1 | An operation is offered for issue |
| op_approx | input | 1 | 1 = approximate mode, 0 = accurate mode, for the offered operation |
| pipe_adv | input | 1 | Pipeline advance. Also acts as the issue ready signal |
| sens_err | input | 32 | Per-bit timing-error flags for the result leaving the pipeline |
| replay_req | output | 1 | Pulse requesting replay of the operation that just left |
| err_seen | output | 1 | Pulse reporting that any flag fired on that operation |

## Verification
Directed patterns place single flags just below N, exactly at N, on bit 22 with N clamped, and on the sign and exponent bits. These separate the mask boundary from an off-by-one error and separate clamping from wrap-around. Other patterns rewrite N in the cycle of issue and while the operation is in flight, stall the pipe with flags present, and interleave modes back to back. These show whether the tag is captured at issue and aligned with the correct stage. Seeded random traffic mixes modes, N values, stalls, bubbles and multi-bit flags, and is compared against a bench reference model.

// File: rtl/fem_pkg.sv
package fem_pkg;
  localparam int FRAC_W = 23;
  localparam int EXP_W  = 8;
  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int NB_W   = $clog2(FRAC_W + 1);

  typedef struct packed {
    logic            vld;
    logic            approx;
    logic [NB_W-1:0] nbits;
  } op_tag_t;
endpackage

// File: rtl/fem_cfg_reg.sv
module fem_cfg_reg
  import fem_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [NB_W-1:0] wr_data,
  output logic [NB_W-1:0] nbits
);
  localparam logic [NB_W-1:0] MAXN = NB_W'(FRAC_W);

  logic [NB_W-1:0] clamped;
  assign clamped = (wr_data > MAXN) ? MAXN : wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n)     nbits <= '0;
    else if (wr_en) nbits <= clamped;
  end

  // R6: the stored count never exceeds the fraction width
  a_r6_clamped: assert property (@(posedge clk) disable iff (!rst_n)
    nbits <= MAXN);
  // R6: a write of an oversized value lands as the maximum
  a_r6_over_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data > MAXN) |=> (nbits == MAXN));
endmodule

// File: rtl/fem_tag_pipe.sv
module fem_tag_pipe
  import fem_pkg::*;
#(
  parameter int DEPTH = 3
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    adv,
  input  op_tag_t in_tag,
  output op_tag_t out_tag
);
  for (genvar g = 0; g < DEPTH; g++) begin : gen_stg
    op_tag_t q;
    op_tag_t d;
    if (g == 0) begin : gen_head
      assign d = in_tag;
    end else begin : gen_body
      assign d = gen_stg[g-1].q;
    end
    always_ff @(posedge clk) begin
      if (!rst_n)   q <= '0;
      else if (adv) q <= d;
    end
  end

  assign out_tag = gen_stg[DEPTH-1].q;

  // R9: a stalled pipe keeps its last stage unchanged
  a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(out_tag));
endmodule

// File: rtl/fem_mask_eval.sv
module fem_mask_eval
  import fem_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              approx,
  input  logic [NB_W-1:0]   nbits,
  input  logic [WORD_W-1:0] flags,
  output logic              replay_req,
  output logic              err_seen
);
  logic [FRAC_W-1:0] ign;
  logic [WORD_W-1:0] kept;

  // thermometer mask over the fraction: bit i ignored when i < N
  for (genvar i = 0; i < FRAC_W; i++) begin : gen_therm
    assign ign[i] = approx && (NB_W'(i) < nbits);
  end

  assign kept = flags & ~{{(WORD_W-FRAC_W){1'b0}}, ign};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      replay_req <= 1'b0;
      err_seen   <= 1'b0;
    end else begin
      replay_req <= fire && (|kept);
      err_seen   <= fire && (|flags);
    end
  end

  // R5: sign and exponent flags always replay
  a_r5_protected: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && |flags[WORD_W-1:FRAC_W]) |=> replay_req);
  // R2: accurate operations replay on any flag
  a_r2_accurate: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !approx && |flags) |=> replay_req);
  // R8: a replay always comes with an error report
  a_r8_replay_seen: assert property (@(posedge clk) disable iff (!rst_n)
    replay_req |-> err_seen);
  // R8: no leaving operation, no output
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> (!replay_req && !err_seen));
endmodule

// File: rtl/fp_err_mask_unit.sv
module fp_err_mask_unit
  import fem_pkg::*;
#(
  parameter int DEPTH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [NB_W-1:0]   cfg_nbits,
  input  logic              op_valid,
  input  logic              op_approx,
  input  logic              pipe_adv,
  input  logic [WORD_W-1:0] sens_err,
  output logic              replay_req,
  output logic              err_seen
);
  logic [NB_W-1:0] nbits_q;
  op_tag_t         issue_tag;
  op_tag_t         tail_tag;
  logic            fire;

  fem_cfg_reg u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr),
    .wr_data (cfg_nbits),
    .nbits   (nbits_q)
  );

  assign issue_tag.vld    = op_valid;
  assign issue_tag.approx = op_approx;
  assign issue_tag.nbits  = nbits_q;

  fem_tag_pipe #(.DEPTH(DEPTH)) u_pipe (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (pipe_adv),
    .in_tag  (issue_tag),
    .out_tag (tail_tag)
  );

  assign fire = pipe_adv && tail_tag.vld;

  fem_mask_eval u_eval (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire       (fire),
    .approx     (tail_tag.approx),
    .nbits      (tail_tag.nbits),
    .flags      (sens_err),
    .replay_req (replay_req),
    .err_seen   (err_seen)
  );

  // R9: outputs only follow an advancing cycle
  a_r9_adv_only: assert property (@(posedge clk) disable iff (!rst_n)
    !pipe_adv |=> !err_seen);
endmodule

// File: tb/fp_err_mask_unit_tb.sv
`timescale 1ns/100ps
module fp_err_mask_unit_tb;
  localparam int D = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr;
  logic [4:0]  cfg_nbits;
  logic        op_valid, op_approx, pipe_adv;
  logic [31:0] sens_err;
  logic        replay_req, err_seen;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic       m_vld [D];
  logic       m_apx [D];
  logic [4:0] m_n   [D];
  logic [4:0] m_cur;

  always #2.5 clk = ~clk;

  fp_err_mask_unit #(.DEPTH(D)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_nbits(cfg_nbits),
    .op_valid(op_valid), .op_approx(op_approx), .pipe_adv(pipe_adv),
    .sens_err(sens_err), .replay_req(replay_req), .err_seen(err_seen)
  );

  function automatic logic [31:0] ign_mask(input logic apx, input logic [4:0] n);
    logic [31:0] m = '0;
    for (int i = 0; i < 23; i++) if (apx && i < n) m[i] = 1'b1;
    return m;
  endfunction

  task automatic step(input string lbl, input logic adv, input logic v,
                      input logic apx, input logic wr, input logic [4:0] wd,
                      input logic [31:0] fl);
    logic er, es;
    pipe_adv = adv; op_valid = v; op_approx = apx;
    cfg_wr = wr; cfg_nbits = wd; sens_err = fl;
    @(posedge clk);
    es = adv && m_vld[D-1] && (fl != 0);
    er = adv && m_vld[D-1] && ((fl & ~ign_mask(m_apx[D-1], m_n[D-1])) != 0);
    if (adv) begin
      for (int k = D-1; k > 0; k--) begin
        m_vld[k] = m_vld[k-1]; m_apx[k] = m_apx[k-1]; m_n[k] = m_n[k-1];
      end
      m_vld[0] = v; m_apx[0] = apx; m_n[0] = m_cur;
    end
    if (wr) m_cur = (wd > 5'd23) ? 5'd23 : wd;
    @(negedge clk);
    checks++;
    if (replay_req !== er || err_seen !== es) begin
      errors++;
      $display("FAIL %s replay=%0b exp %0b seen=%0b exp %0b",
               lbl, replay_req, er, err_seen, es);
    end
  endtask

  task automatic run_op(input string lbl, input logic apx, input logic [31:0] fl);
    step(lbl, 1, 1, apx, 0, 0, 0);
    for (int b = 0; b < D-1; b++) step(lbl, 1, 0, 0, 0, 0, 0);
    step(lbl, 1, 0, 0, 0, 0, fl);
  endtask

  task automatic set_n(input string lbl, input logic [4:0] n);
    step(lbl, 1, 0, 0, 1, n, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; cfg_wr = 0; cfg_nbits = 0; op_valid = 0; op_approx = 0;
    pipe_adv = 0; sens_err = 0; m_cur = 0;
    for (int k = 0; k < D; k++) begin m_vld[k] = 0; m_apx[k] = 0; m_n[k] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    checks++;
    if (replay_req !== 0 || err_seen !== 0) begin
      errors++;
      $display("FAIL R1 reset outputs %0b%0b exp 00", replay_req, err_seen);
    end
    run_op("R1 N=0 masks nothing", 1, 32'h1);
    set_n("R3 set N", 8);
    run_op("R3 below N ignored", 1, 32'h80);
    run_op("R4 at N replays", 1, 32'h100);
    run_op("R2 accurate bit0", 0, 32'h1);
    run_op("R5 sign", 1, 32'h8000_0000);
    run_op("R5 exponent", 1, 32'h0080_0000);
    set_n("R6 write 31", 31);
    run_op("R6 bit22 masked", 1, 32'h0040_0000);
    run_op("R6 bit23 replays", 1, 32'h0080_0000);
    set_n("R7 set N", 4);
    step("R7 issue", 1, 1, 1, 0, 0, 0);
    step("R7 write in flight", 1, 0, 0, 1, 0, 0);
    step("R7 bubble", 1, 0, 0, 0, 0, 0);
    step("R7 old N kept", 1, 0, 0, 0, 0, 32'h8);
    step("R7 write at issue", 1, 1, 1, 1, 20, 0);
    step("R7 bubble", 1, 0, 0, 0, 0, 0);
    step("R7 bubble", 1, 0, 0, 0, 0, 0);
    step("R7 pre-write N", 1, 0, 0, 0, 0, 32'h400);
    step("R9 issue", 1, 1, 1, 0, 0, 0);
    step("R9 stall", 0, 0, 0, 0, 0, 32'hFFFF_FFFF);
    step("R9 bubble", 1, 0, 0, 0, 0, 0);
    step("R9 stall", 0, 0, 0, 0, 0, 32'hFFFF_FFFF);
    step("R9 stall", 0, 0, 0, 0, 0, 32'hFFFF_FFFF);
    step("R9 bubble", 1, 0, 0, 0, 0, 0);
    step("R9 leaves", 1, 0, 0, 0, 0, 32'h4);
    set_n("R10 set N", 10);
    step("R10 acc", 1, 1, 0, 0, 0, 0);
    step("R10 apx", 1, 1, 1, 0, 0, 0);
    step("R10 bubble", 1, 0, 0, 0, 0, 0);
    step("R10 acc leaves", 1, 0, 0, 0, 0, 32'h20);
    step("R10 apx leaves", 1, 0, 0, 0, 0, 32'h20);
    run_op("R8 clean op", 0, 32'h0);
    step("R8 flags no op", 1, 0, 0, 0, 0, 32'h0000_0F0F);
    for (int t = 0; t < 3000; t++) begin
      logic [31:0] fl;
      int sel = $urandom_range(0, 9);
      fl = (sel < 3) ? 32'h0 :
           (sel < 8) ? (32'h1 << $urandom_range(0, 31)) : $urandom;
      step("R10 random", ($urandom_range(0, 5) != 0), $urandom_range(0, 1),
           $urandom_range(0, 1), ($urandom_range(0, 9) == 0),
           5'($urandom_range(0, 31)), fl);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule